// File: doc/BRIEF.md
# PC Keyboard Controller Command Processor

This block is the host-facing half of a PC-style dual-channel input controller that serves a keyboard and an auxiliary (pointing) device. The host sees two byte-wide ports selected by one address bit: a data port (address 0) and a command/status port (address 1). Command bytes are decoded here. The block holds the mode byte, the status byte and the output-port byte. It drives the A20 gate and a one-cycle system reset request.

Some commands take an operand. Such a command arms a pending latch, and the next data-port write supplies the operand and clears the latch. A data-port write with nothing armed goes to the keyboard. Any byte the controller itself produces goes into a single-entry response slot, tagged as keyboard- or auxiliary-sourced. A downstream output-buffer arbiter drains the slot by pulsing a take input. The arbiter also watches the mode byte to know which interrupts are enabled and which interfaces are disabled. Serial links and device models are outside this block.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset:
  - the mode byte is 0x03;
  - the status byte is 0x18;
  - the output-port byte is 0xCF, so A20 is high and command 0xD0 yields 0xCF;
  - the response slot is empty;
  - nothing is armed.
- R2: Command 0x20 loads the current mode byte into the response slot as a keyboard-sourced byte (aux flag 0). Command 0x60 arms a mode write, and the next data-port byte becomes the whole mode byte.
- R3: Commands 0xD1, 0xD2, 0xD3 and 0xD4 arm the operand of the next data-port byte, which is used as follows:
  - 0xD1 writes the output port;
  - 0xD2 enters the response slot as a keyboard-sourced byte;
  - 0xD3 enters the response slot as an aux-sourced byte (aux flag 1);
  - 0xD4 is sent to the auxiliary device on its transmit strobe.
  The latch is then empty, so a further data byte goes to the keyboard. Commands that do not arm leave an armed latch untouched.
- R4: Mode bit 5 disables the aux interface and mode bit 4 disables the keyboard interface. Command 0xA7 sets bit 5 and 0xA8 clears it. Command 0xAD sets bit 4 and 0xAE clears it. The other mode bits do not change.
- R5: Fixed responses enter the slot as keyboard-sourced bytes:
  - 0xAA yields 0x55 and sets status bit 2, which stays set until reset;
  - 0xA9 and 0xAB yield 0x00;
  - 0xC0 yields 0x80;
  - 0xD0 yields the output-port byte.
- R6: Any command 0xF0 to 0xFF is a pulse command. With bit 0 clear it raises the system reset request for exactly one cycle. With bit 0 set it changes nothing.
- R7: Command 0xDF sets output-port bit 1 and raises A20. Command 0xDD clears bit 1 and lowers A20.
- R8: An output-port write (under 0xD1) stores the byte and drives A20 from its bit 1. It raises the reset request for one cycle when its bit 0 is 0.
- R9: A data-port write with nothing armed pulses the keyboard transmit strobe with the byte and clears mode bit 4. A data byte under 0xD4 clears mode bit 5.
- R10: A command code not listed in R2 to R7 pulses the error output for one cycle. It leaves the following unchanged: the mode byte, the output port, A20, the response slot and the armed latch.
- R11: Reading address 1 returns the status byte, and the read has no side effects. The status bits are:
  - bit 0 is set while the response slot is full;
  - bit 2 is the self-test flag;
  - bit 3 is 1 after a command write and 0 after a data write;
  - bit 4 is always 1;
  - all other bits are 0.
  Reading address 0 returns 0x00.
- R12: The response slot holds one byte. A new response overwrites it, even in the cycle it is taken. A take with no new response empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Status byte when bus_addr is 1, else 0x00 |
| mode_o | output | 8 | Current mode byte, for the arbiter |
| resp_valid | output | 1 | Response slot full |
| resp_data | output | 8 | Response byte |
| resp_aux | output | 1 | Response is aux-sourced |
| resp_take | input | 1 | Arbiter drains the response slot |
| kbd_tx_stb | output | 1 | One-cycle strobe: byte for the keyboard |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| aux_tx_stb | output | 1 | One-cycle strobe: byte for the aux device |
| aux_tx_data | output | 8 | Byte for the aux device |
| a20_gate | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_cmd | output | 1 | One-cycle pulse on an unsupported command |

## Verification
The bench builds the block with its default parameters:
- mode reset 0x03;
- output-port reset 0xCF;
- self-test answer 0x55;
- input-port answer 0x80.

These defaults make the reset bytes and fixed answers directly comparable with R1 and R5. They also let the randomized command stream reach every branch of the decoder, including both halves of the pulse range and undecoded codes. Because the output-port reset value has bit 0 set, a reset request can only come from a pulse command or an explicit output-port write. The armed-latch interaction is exercised by random interleaving of arming commands, non-arming commands and data writes.

// File: rtl/kbc_pkg.sv
// Shared definitions for the keyboard controller command processor.
// Assumes byte-wide host ports; command values are the host-visible encoding.
package kbc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_MODE_RD   = 8'h20;
    localparam byte_t CMD_MODE_WR   = 8'h60;
    localparam byte_t CMD_AUX_OFF   = 8'hA7;
    localparam byte_t CMD_AUX_ON    = 8'hA8;
    localparam byte_t CMD_AUX_TEST  = 8'hA9;
    localparam byte_t CMD_SELF_TEST = 8'hAA;
    localparam byte_t CMD_KBD_TEST  = 8'hAB;
    localparam byte_t CMD_KBD_OFF   = 8'hAD;
    localparam byte_t CMD_KBD_ON    = 8'hAE;
    localparam byte_t CMD_INP_RD    = 8'hC0;
    localparam byte_t CMD_OUTP_RD   = 8'hD0;
    localparam byte_t CMD_OUTP_WR   = 8'hD1;
    localparam byte_t CMD_KBD_ECHO  = 8'hD2;
    localparam byte_t CMD_AUX_ECHO  = 8'hD3;
    localparam byte_t CMD_AUX_SEND  = 8'hD4;
    localparam byte_t CMD_GATE_LO   = 8'hDD;
    localparam byte_t CMD_GATE_HI   = 8'hDF;
    localparam byte_t ARM_NONE      = 8'h00;

    localparam int MODE_KBD_OFF_BIT = 4;
    localparam int MODE_AUX_OFF_BIT = 5;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_RESP_MODE, ACT_ARM, ACT_SET_MODE, ACT_CLR_MODE,
        ACT_SELFTEST, ACT_RESP_CONST, ACT_RESP_OUTP, ACT_GATE_HI,
        ACT_GATE_LO, ACT_RESET, ACT_NOP, ACT_BAD
    } act_e;

    typedef struct packed {
        act_e  act;
        byte_t arg;
    } dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
// Combinational command decoder. It folds the pulse range 0xF0-0xFF onto
// reset (bit 0 clear) or no-op (bit 0 set). It returns an action and an
// argument: a mode mask, a constant response byte or the arming code.
// Assumes a valid byte whenever the caller qualifies it.
module kbc_cmd_decode
    import kbc_pkg::*;
#(
    parameter byte_t SELFTEST_VAL = 8'h55,
    parameter byte_t INPORT_VAL   = 8'h80
) (
    input  byte_t code,
    output dec_t  dec
);
    localparam byte_t KBD_MASK = byte_t'(1) << MODE_KBD_OFF_BIT;
    localparam byte_t AUX_MASK = byte_t'(1) << MODE_AUX_OFF_BIT;

    // Map a command byte to an action.
    always_comb begin
        dec = '{act: ACT_BAD, arg: '0};
        if (code[7:4] == 4'hF) begin
            dec.act = code[0] ? ACT_NOP : ACT_RESET;
        end else begin
            case (code)
                CMD_MODE_RD:   dec.act = ACT_RESP_MODE;
                CMD_MODE_WR, CMD_OUTP_WR, CMD_KBD_ECHO,
                CMD_AUX_ECHO, CMD_AUX_SEND:
                               dec = '{act: ACT_ARM, arg: code};
                CMD_AUX_OFF:   dec = '{act: ACT_SET_MODE, arg: AUX_MASK};
                CMD_AUX_ON:    dec = '{act: ACT_CLR_MODE, arg: AUX_MASK};
                CMD_KBD_OFF:   dec = '{act: ACT_SET_MODE, arg: KBD_MASK};
                CMD_KBD_ON:    dec = '{act: ACT_CLR_MODE, arg: KBD_MASK};
                CMD_SELF_TEST: dec = '{act: ACT_SELFTEST, arg: SELFTEST_VAL};
                CMD_AUX_TEST, CMD_KBD_TEST:
                               dec = '{act: ACT_RESP_CONST, arg: 8'h00};
                CMD_INP_RD:    dec = '{act: ACT_RESP_CONST, arg: INPORT_VAL};
                CMD_OUTP_RD:   dec.act = ACT_RESP_OUTP;
                CMD_GATE_HI:   dec.act = ACT_GATE_HI;
                CMD_GATE_LO:   dec.act = ACT_GATE_LO;
                default:       dec.act = ACT_BAD;
            endcase
        end
    end
endmodule

// File: rtl/kbc_resp_slot.sv
// Single-entry response register between the command processor and the
// output-buffer arbiter. A load wins over a take in the same cycle.
// Assumes the arbiter pulses take once per byte it consumes.
module kbc_resp_slot
    import kbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  load_aux,
    input  logic  take,
    output logic  valid,
    output byte_t data,
    output logic  aux
);
    // Hold the newest response until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            aux   <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            aux   <= load_aux;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    // R12: the slot only empties when the arbiter took it.
    p_drop_on_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(take));
    // R12: a load always leaves the slot full with the loaded byte.
    p_load_fills_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid && data == $past(load_data)));
endmodule

// File: rtl/kbc_outport.sv
// Output-port register with A20 gate and reset-request pulse.
// Assumes at most one of full write, gate-high, gate-low per cycle.
module kbc_outport
    import kbc_pkg::*;
#(
    parameter byte_t RST_VAL = 8'hCF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_all,
    input  byte_t wr_data,
    input  logic  gate_hi,
    input  logic  gate_lo,
    input  logic  pulse_rst,
    output byte_t outp,
    output logic  a20,
    output logic  rst_req
);
    // Update the output-port byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       outp <= RST_VAL;
        else if (wr_all)  outp <= wr_data;
        else if (gate_hi) outp[1] <= 1'b1;
        else if (gate_lo) outp[1] <= 1'b0;
    end

    // Raise a one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= pulse_rst | (wr_all & ~wr_data[0]);
    end

    assign a20 = outp[1];

    // R8: an output-port write drives A20 from bit 1 of the written byte.
    p_a20_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all |=> (a20 == $past(wr_data[1])));
    // R7: gate commands move A20.
    p_gate_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi && !wr_all) |=> a20);
endmodule

// File: rtl/kbc_cmd_proc.sv
// Host-side command processor of a dual-channel keyboard controller.
// It decodes commands, holds the mode, status and armed-operand state,
// routes data-port bytes, and feeds the response slot and the output port.
// Assumes single-cycle write strobes and one byte per strobe.
module kbc_cmd_proc
    import kbc_pkg::*;
#(
    parameter byte_t MODE_RST     = 8'h03,
    parameter byte_t OUTP_RST     = 8'hCF,
    parameter byte_t SELFTEST_VAL = 8'h55,
    parameter byte_t INPORT_VAL   = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] mode_o,
    output logic       resp_valid,
    output logic [7:0] resp_data,
    output logic       resp_aux,
    input  logic       resp_take,
    output logic       kbd_tx_stb,
    output logic [7:0] kbd_tx_data,
    output logic       aux_tx_stb,
    output logic [7:0] aux_tx_data,
    output logic       a20_gate,
    output logic       sys_reset_req,
    output logic       bad_cmd
);
    logic  cmd_wr, dat_wr;
    dec_t  dec;
    byte_t mode_q, armed_q, outp;
    logic  selftest_q, cmdflag_q;
    logic  rsp_ld, rsp_aux_ld;
    byte_t rsp_byte;

    assign cmd_wr = bus_wr & bus_addr;
    assign dat_wr = bus_wr & ~bus_addr;

    kbc_cmd_decode #(.SELFTEST_VAL(SELFTEST_VAL), .INPORT_VAL(INPORT_VAL))
        u_dec (.code(bus_wdata), .dec(dec));

    // Choose what, if anything, enters the response slot this cycle.
    always_comb begin
        rsp_ld = 1'b0; rsp_aux_ld = 1'b0; rsp_byte = '0;
        if (cmd_wr) begin
            case (dec.act)
                ACT_RESP_MODE:  begin rsp_ld = 1'b1; rsp_byte = mode_q;  end
                ACT_SELFTEST,
                ACT_RESP_CONST: begin rsp_ld = 1'b1; rsp_byte = dec.arg; end
                ACT_RESP_OUTP:  begin rsp_ld = 1'b1; rsp_byte = outp;    end
                default: ;
            endcase
        end else if (dat_wr && (armed_q == CMD_KBD_ECHO || armed_q == CMD_AUX_ECHO)) begin
            rsp_ld = 1'b1; rsp_byte = bus_wdata;
            rsp_aux_ld = (armed_q == CMD_AUX_ECHO);
        end
    end

    kbc_resp_slot u_slot (
        .clk(clk), .rst_n(rst_n), .load(rsp_ld), .load_data(rsp_byte),
        .load_aux(rsp_aux_ld), .take(resp_take),
        .valid(resp_valid), .data(resp_data), .aux(resp_aux));

    kbc_outport #(.RST_VAL(OUTP_RST)) u_outp (
        .clk(clk), .rst_n(rst_n),
        .wr_all(dat_wr && armed_q == CMD_OUTP_WR), .wr_data(bus_wdata),
        .gate_hi(cmd_wr && dec.act == ACT_GATE_HI),
        .gate_lo(cmd_wr && dec.act == ACT_GATE_LO),
        .pulse_rst(cmd_wr && dec.act == ACT_RESET),
        .outp(outp), .a20(a20_gate), .rst_req(sys_reset_req));

    // Mode byte: mask commands, full write, and implicit re-enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (cmd_wr && dec.act == ACT_SET_MODE) begin
            mode_q <= mode_q | dec.arg;
        end else if (cmd_wr && dec.act == ACT_CLR_MODE) begin
            mode_q <= mode_q & ~dec.arg;
        end else if (dat_wr) begin
            case (armed_q)
                ARM_NONE:     mode_q[MODE_KBD_OFF_BIT] <= 1'b0;
                CMD_MODE_WR:  mode_q <= bus_wdata;
                CMD_AUX_SEND: mode_q[MODE_AUX_OFF_BIT] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Armed-operand latch: set by arming commands, cleared by any data write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          armed_q <= ARM_NONE;
        else if (cmd_wr && dec.act == ACT_ARM) armed_q <= dec.arg;
        else if (dat_wr)                     armed_q <= ARM_NONE;
    end

    // Status flags: sticky self-test, last-write-was-command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selftest_q <= 1'b0;
            cmdflag_q  <= 1'b1;
        end else begin
            if (cmd_wr && dec.act == ACT_SELFTEST) selftest_q <= 1'b1;
            if (bus_wr) cmdflag_q <= bus_addr;
        end
    end

    // Device transmit strobes and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_tx_stb <= 1'b0; aux_tx_stb <= 1'b0; bad_cmd <= 1'b0;
            kbd_tx_data <= '0;  aux_tx_data <= '0;
        end else begin
            kbd_tx_stb <= dat_wr && armed_q == ARM_NONE;
            aux_tx_stb <= dat_wr && armed_q == CMD_AUX_SEND;
            bad_cmd    <= cmd_wr && dec.act == ACT_BAD;
            if (dat_wr && armed_q == ARM_NONE)     kbd_tx_data <= bus_wdata;
            if (dat_wr && armed_q == CMD_AUX_SEND) aux_tx_data <= bus_wdata;
        end
    end

    assign mode_o    = mode_q;
    assign bus_rdata = bus_addr ? {3'b000, 1'b1, cmdflag_q, selftest_q, 1'b0, resp_valid}
                                : 8'h00;

    // R3: a data write always leaves nothing armed.
    p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> (armed_q == ARM_NONE));
    // R6: an even pulse command requests a reset on the next cycle.
    p_pulse_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[7:4] == 4'hF && !bus_wdata[0]) |=> sys_reset_req);
    // R10: an unsupported command changes neither mode nor A20 nor the slot.
    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |-> ($stable(mode_o) && $stable(a20_gate) && $stable(resp_data)));
    // R9: a keyboard byte leaves the keyboard interface enabled.
    p_kbd_reenable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_tx_stb |-> !mode_o[MODE_KBD_OFF_BIT]);
    // R5: the self-test flag never clears outside reset.
    p_selftest_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rdata[2] && bus_addr) && bus_addr |-> bus_rdata[2]);
endmodule

// File: tb/tb_kbc_cmd_proc.sv
`timescale 1ns/1ps
module tb_kbc_cmd_proc;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0, resp_take = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, mode_o, resp_data, kbd_tx_data, aux_tx_data;
    logic       resp_valid, resp_aux, kbd_tx_stb, aux_tx_stb, a20_gate, sys_reset_req, bad_cmd;

    int total = 0, bad = 0;

    // expected model
    logic [7:0] m_mode, m_outp, m_armed, m_rdata, m_kdata, m_adata;
    logic       m_rv, m_raux, m_self, m_cmdf, m_rst, m_bad, m_kstb, m_astb;

    kbc_cmd_proc dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_aux(resp_aux),
        .resp_take(resp_take), .kbd_tx_stb(kbd_tx_stb), .kbd_tx_data(kbd_tx_data),
        .aux_tx_stb(aux_tx_stb), .aux_tx_data(aux_tx_data), .a20_gate(a20_gate),
        .sys_reset_req(sys_reset_req), .bad_cmd(bad_cmd));

    always #2 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {3'b000, 1'b1, m_cmdf, m_self, 1'b0, m_rv};
    endfunction

    task automatic model_reset();
        m_mode = 8'h03; m_outp = 8'hCF; m_armed = 8'h00; m_rdata = 8'h00;
        m_rv = 0; m_raux = 0; m_self = 0; m_cmdf = 1;
        m_rst = 0; m_bad = 0; m_kstb = 0; m_astb = 0; m_kdata = 0; m_adata = 0;
    endtask

    task automatic put_resp(input logic [7:0] v, input logic ax);
        m_rv = 1; m_rdata = v; m_raux = ax;
    endtask

    task automatic model_cmd(input logic [7:0] c0);
        logic [7:0] c = c0;
        m_cmdf = 1;
        if (c[7:4] == 4'hF) c = c[0] ? 8'hFF : 8'hFE;
        case (c)
            8'h20: put_resp(m_mode, 0);
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: m_armed = c;
            8'hA7: m_mode[5] = 1;
            8'hA8: m_mode[5] = 0;
            8'hAD: m_mode[4] = 1;
            8'hAE: m_mode[4] = 0;
            8'hA9, 8'hAB: put_resp(8'h00, 0);
            8'hAA: begin m_self = 1; put_resp(8'h55, 0); end
            8'hC0: put_resp(8'h80, 0);
            8'hD0: put_resp(m_outp, 0);
            8'hDD: m_outp[1] = 0;
            8'hDF: m_outp[1] = 1;
            8'hFE: m_rst = 1;
            8'hFF: ;
            default: m_bad = 1;
        endcase
    endtask

    task automatic model_data(input logic [7:0] d);
        m_cmdf = 0;
        case (m_armed)
            8'h00: begin m_kstb = 1; m_kdata = d; m_mode[4] = 0; end
            8'h60: m_mode = d;
            8'hD1: begin m_outp = d; if (!d[0]) m_rst = 1; end
            8'hD2: put_resp(d, 0);
            8'hD3: put_resp(d, 1);
            8'hD4: begin m_astb = 1; m_adata = d; m_mode[5] = 0; end
            default: ;
        endcase
        m_armed = 8'h00;
    endtask

    task automatic compare_all(input string tag);
        bus_addr = 1'b1;
        #0.5;
        chk(tag, "mode", mode_o, m_mode);
        chk(tag, "a20", a20_gate, m_outp[1]);
        chk(tag, "resp_valid", resp_valid, m_rv);
        if (m_rv) begin
            chk(tag, "resp_data", resp_data, m_rdata);
            chk(tag, "resp_aux", resp_aux, m_raux);
        end
        chk(tag, "reset_req", sys_reset_req, m_rst);
        chk(tag, "bad_cmd", bad_cmd, m_bad);
        chk(tag, "kbd_stb", kbd_tx_stb, m_kstb);
        chk(tag, "aux_stb", aux_tx_stb, m_astb);
        if (m_kstb) chk(tag, "kbd_data", kbd_tx_data, m_kdata);
        if (m_astb) chk(tag, "aux_data", aux_tx_data, m_adata);
        chk(tag, "status", bus_rdata, exp_status());
    endtask

    task automatic clr_pulses();
        m_rst = 0; m_bad = 0; m_kstb = 0; m_astb = 0;
    endtask

    task automatic op_wr(input logic a, input logic [7:0] d, input string tag);
        @(negedge clk);
        clr_pulses();
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        if (a) model_cmd(d); else model_data(d);
        @(negedge clk);
        bus_wr = 0;
        compare_all(tag);
    endtask

    task automatic op_take(input string tag);
        @(negedge clk);
        clr_pulses();
        resp_take = 1; m_rv = 0;
        @(negedge clk);
        resp_take = 0;
        compare_all(tag);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [7:0] KNOWN [18] = '{8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA,
        8'hAB, 8'hAD, 8'hAE, 8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF, 8'hF0};

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all("R1");
        chk("R1", "reset status", bus_rdata, 8'h18);
        chk("R1", "reset mode", mode_o, 8'h03);
        op_wr(1, 8'hD0, "R1");
        chk("R1", "outport after reset", resp_data, 8'hCF);
        // R11: status reads alone change nothing
        bus_addr = 1; repeat (3) @(negedge clk); compare_all("R11");
        bus_addr = 0; #0.5; chk("R11", "data read", bus_rdata, 8'h00);
        op_take("R12");
        // directed
        op_wr(1, 8'h20, "R2");
        op_wr(1, 8'h60, "R2"); op_wr(0, 8'h5A, "R2");
        op_wr(1, 8'h20, "R2");
        op_wr(1, 8'hAA, "R5"); op_wr(1, 8'hC0, "R5"); op_wr(1, 8'hA9, "R5");
        op_wr(1, 8'hD1, "R8"); op_wr(0, 8'hCC, "R8");
        op_wr(1, 8'hD1, "R8"); op_wr(0, 8'h0F, "R8");
        op_wr(1, 8'hDD, "R7"); op_wr(1, 8'hD0, "R5"); op_wr(1, 8'hDF, "R7");
        op_wr(1, 8'hF0, "R6"); op_wr(1, 8'hF1, "R6"); op_wr(1, 8'hFA, "R6"); op_wr(1, 8'hFF, "R6");
        op_wr(1, 8'hD2, "R3"); op_wr(0, 8'h11, "R3");
        op_wr(1, 8'hD3, "R3"); op_wr(0, 8'h22, "R3"); op_wr(0, 8'h33, "R3");
        op_wr(1, 8'hAD, "R4"); op_wr(1, 8'hA7, "R4"); op_wr(1, 8'hAE, "R4"); op_wr(1, 8'hAD, "R4");
        op_wr(0, 8'h44, "R9");
        op_wr(1, 8'hD4, "R9"); op_wr(0, 8'h55, "R9");
        op_wr(1, 8'hD4, "R10"); op_wr(1, 8'hA1, "R10"); op_wr(1, 8'h00, "R10");
        op_wr(1, 8'h42, "R10"); op_wr(0, 8'h66, "R10");
        // R12: load in the same cycle as take wins
        @(negedge clk); clr_pulses();
        bus_wr = 1; bus_addr = 1; bus_wdata = 8'hAB; resp_take = 1; model_cmd(8'hAB);
        @(negedge clk); bus_wr = 0; resp_take = 0; compare_all("R12");
        op_take("R12");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [7:0] v = 8'($urandom);
            if (r < 4)       op_wr(1, KNOWN[$urandom_range(0, 17)] | ((r == 0) ? {4'h0, v[3:0] & 4'h1} : 8'h00), "R3");
            else if (r == 4) op_wr(1, v, "R10");
            else if (r < 8)  op_wr(0, v, "R9");
            else if (r == 8) op_take("R12");
            else begin @(negedge clk); clr_pulses(); compare_all("R11"); end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule